// File: doc/BRIEF.md
# DDR3 Power-Up Reset Sequencer

This block brings an external DDR3 device out of reset after power-up. It counts time in reference-clock cycles: one parameter gives the number of cycles per microsecond, and every interval is derived from it. A start pulse begins the sequence. The block holds the memory reset pin at its asserted level for the reset-hold interval and then releases it. It then keeps clock enable low for the CKE wait. That wait is the longer of two values: a fixed settle time, and a programmed cycle count multiplied by two or three.

With clock enable high, the block raises an initialization request to the memory controller. It holds the request until the controller answers with a completion strobe. If no answer arrives within a bounded window, the block raises an error flag. After a completion it runs a short reset of the transaction manager: the enable goes low for one microsecond, then high for one microsecond. It then raises done.

A strap input sets the asserted level of the reset pin, so that silicon with either polarity can be served. Done and error hold until the next start pulse. A start pulse that arrives while a sequence is in progress has no effect.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: On an accepted start, the reset pin is driven to its asserted level in the next cycle and stays there for exactly RESET_US*CYC_PER_US cycles.
- R2: When the programmed count times its factor does not exceed CKE_US*CYC_PER_US, clock enable rises exactly CKE_US*CYC_PER_US cycles after the reset pin is released.
- R3: When the programmed count `cke_cfg_i` times its factor (3 when `cke_x3_i`=1, otherwise 2) exceeds the fixed interval, that product sets the number of cycles between reset release and clock enable rising.
- R4: `init_req_o` rises in the same cycle as `cke_o`. It stays high until a cycle in which `init_done_i` is high, and it is low from the following cycle on.
- R5: If `init_done_i` is not seen within TMO_US*CYC_PER_US cycles of the request rising, `error_o` rises at the end of that window, `init_req_o` falls, and `done_o` stays low.
- R6: After completion, `tm_en_o` is low for exactly CYC_PER_US cycles and then high for exactly CYC_PER_US cycles. `done_o` rises after that.
- R7: A start pulse that arrives while a sequence is running (any phase other than idle, done or error) is ignored, and the timing of the running sequence is unchanged.
- R8: `done_o` and `error_o` hold until the next start pulse. In the cycle after that pulse both are low, clock enable is low and the reset pin is asserted again.
- R9: A completion strobe in the last cycle of the timeout window counts as success: no error is raised and the transaction-manager reset follows.
- R10: With `rst_pol_hi_i`=1 the asserted reset level is high; with `rst_pol_hi_i`=0 it is low. After `rst_n` the block is idle: reset asserted, `cke_o`, `init_req_o`, `done_o` and `error_o` low, `tm_en_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| rst_pol_hi_i | input | 1 | Strap: 1 = memory reset asserted high, 0 = asserted low |
| cke_cfg_i | input | CFG_W | Programmed CKE delay count, before scaling |
| cke_x3_i | input | 1 | Scale factor select: 1 = times 3, 0 = times 2 |
| init_done_i | input | 1 | Completion strobe from the controller |
| mem_rst_o | output | 1 | Memory reset pin level |
| cke_o | output | 1 | Memory clock enable |
| init_req_o | output | 1 | Initialization request to the controller |
| tm_en_o | output | 1 | Transaction-manager enable |
| done_o | output | 1 | Sequence completed successfully |
| error_o | output | 1 | Completion wait timed out |

## Verification
Two events can fall in the same cycle. The first is the controller's completion strobe arriving on the final cycle of the timeout window, where completion and timeout meet. The bench provokes this by placing the strobe exactly TMO_US*CYC_PER_US-1 cycles after the request rises. It passes only if the transaction-manager enable drops and the error flag stays low. The second is a start pulse landing in the middle of the CKE wait. It is judged by measuring the wait, which must match an undisturbed run exactly.

// File: rtl/ddr3_pwrup_pkg.sv
package ddr3_pwrup_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RST   = 3'd1,
        S_CKEW  = 3'd2,
        S_INIT  = 3'd3,
        S_TMOFF = 3'd4,
        S_TMON  = 3'd5,
        S_DONE  = 3'd6,
        S_FAIL  = 3'd7
    } seq_state_e;

endpackage

// File: rtl/ddr3_cke_wait_calc.sv
module ddr3_cke_wait_calc #(
    parameter int     CFG_W     = 17,
    parameter int     OUT_W     = 20,
    parameter longint FIXED_CYC = 100
) (
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             x3_i,
    output logic [OUT_W-1:0] wait_o
);
    logic [OUT_W-1:0] scaled;
    logic [OUT_W-1:0] floor_cyc;

    // Longer of the fixed settle time and the scaled programmed count.
    always_comb begin
        floor_cyc = OUT_W'(FIXED_CYC);
        scaled    = OUT_W'(cfg_i) * (x3_i ? OUT_W'(3) : OUT_W'(2));
        wait_o    = (scaled > floor_cyc) ? scaled : floor_cyc;
    end
endmodule

// File: rtl/ddr3_rst_pin.sv
module ddr3_rst_pin (
    input  logic assert_i,
    input  logic pol_hi_i,
    output logic pin_o
);
    // The strap picks the electrical level that means "in reset".
    always_comb pin_o = pol_hi_i ? assert_i : !assert_i;
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
    import ddr3_pwrup_pkg::*;
#(
    parameter int CYC_PER_US = 24,
    parameter int RESET_US   = 200,
    parameter int CKE_US     = 500,
    parameter int TMO_US     = 1000000,
    parameter int CFG_W      = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rst_pol_hi_i,
    input  logic [CFG_W-1:0] cke_cfg_i,
    input  logic             cke_x3_i,
    input  logic             init_done_i,
    output logic             mem_rst_o,
    output logic             cke_o,
    output logic             init_req_o,
    output logic             tm_en_o,
    output logic             done_o,
    output logic             error_o
);
    localparam longint RST_CYC = longint'(RESET_US) * CYC_PER_US;
    localparam longint CKE_CYC = longint'(CKE_US) * CYC_PER_US;
    localparam longint TMO_CYC = longint'(TMO_US) * CYC_PER_US;
    localparam longint US_CYC  = longint'(CYC_PER_US);
    localparam longint SCL_MAX = 3 * ((longint'(1) << CFG_W) - 1);
    localparam longint BIG_A   = (TMO_CYC > SCL_MAX) ? TMO_CYC : SCL_MAX;
    localparam longint BIG_B   = (RST_CYC > CKE_CYC) ? RST_CYC : CKE_CYC;
    localparam longint BIG     = (BIG_A > BIG_B) ? BIG_A : BIG_B;
    localparam int     CNT_W   = $clog2(BIG + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CNT_W-1:0] cke_wait;
    logic             rst_active;
    logic             busy;

    ddr3_cke_wait_calc #(
        .CFG_W    (CFG_W),
        .OUT_W    (CNT_W),
        .FIXED_CYC(CKE_CYC)
    ) i_wait (
        .cfg_i (cke_cfg_i),
        .x3_i  (cke_x3_i),
        .wait_o(cke_wait)
    );

    ddr3_rst_pin i_pin (
        .assert_i(rst_active),
        .pol_hi_i(rst_pol_hi_i),
        .pin_o   (mem_rst_o)
    );

    // Each timed phase loads its length minus one and leaves when the count reaches zero.
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start_i) begin
                    seq_d.st  = S_RST;
                    seq_d.cnt = CNT_W'(RST_CYC - 1);
                end
            end
            S_RST: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st  = S_CKEW;
                    seq_d.cnt = cke_wait - CNT_W'(1);
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            S_CKEW: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st  = S_INIT;
                    seq_d.cnt = CNT_W'(TMO_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            S_INIT: begin
                // A completion strobe beats expiry in the same cycle.
                if (init_done_i) begin
                    seq_d.st  = S_TMOFF;
                    seq_d.cnt = CNT_W'(US_CYC - 1);
                end else if (seq_q.cnt == '0) begin
                    seq_d.st  = S_FAIL;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            S_TMOFF: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st  = S_TMON;
                    seq_d.cnt = CNT_W'(US_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            S_TMON: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = S_DONE;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: seq_d = seq_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        rst_active = (seq_q.st == S_IDLE) || (seq_q.st == S_RST);
        busy       = !(seq_q.st inside {S_IDLE, S_DONE, S_FAIL});
        cke_o      = seq_q.st inside {S_INIT, S_TMOFF, S_TMON, S_DONE, S_FAIL};
        init_req_o = (seq_q.st == S_INIT);
        tm_en_o    = (seq_q.st != S_TMOFF);
        done_o     = (seq_q.st == S_DONE);
        error_o    = (seq_q.st == S_FAIL);
    end

    p_cke_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> !rst_active);

    p_req_with_cke_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_req_o |-> cke_o);

    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req_o && init_done_i) |=> (!init_req_o && !error_o));

    p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i && seq_q.st != S_RST) |=> !rst_active);

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    p_error_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !start_i) |=> error_o);

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_o || error_o) && start_i) |=> (rst_active && !cke_o));
endmodule

// File: tb/test_ddr3_pwrup_seq.sv
`timescale 1ns/1ps
module test_ddr3_pwrup_seq;
    localparam int CYC  = 2;
    localparam int RUS  = 10;
    localparam int CUS  = 25;
    localparam int TUS  = 40;
    localparam int RSTC = RUS * CYC;
    localparam int CKEC = CUS * CYC;
    localparam int TMOC = TUS * CYC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pol = 1'b0;
    logic [16:0] cfg = '0;
    logic        x3 = 1'b0;
    logic        idone = 1'b0;
    logic        mem_rst, cke, init_req, tm_en, done, error;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = !clk;

    ddr3_pwrup_seq #(
        .CYC_PER_US(CYC), .RESET_US(RUS), .CKE_US(CUS), .TMO_US(TUS), .CFG_W(17)
    ) i_ddr3_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rst_pol_hi_i(pol),
        .cke_cfg_i(cfg), .cke_x3_i(x3), .init_done_i(idone),
        .mem_rst_o(mem_rst), .cke_o(cke), .init_req_o(init_req), .tm_en_o(tm_en),
        .done_o(done), .error_o(error)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    // Runs one sequence from start; all counts are negedge-sampled cycles.
    task automatic run_seq(input bit p, input logic [16:0] c, input bit s3, input int exp_w,
                           input bit do_ack, input int ack_at, input bit poke);
        int k, j, m;
        pol = p; cfg = c; x3 = s3;
        @(negedge clk);
        start = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            k++;
            if (k == 1) begin
                // R8: start clears flags and reasserts reset
                chk(!done && !error && !cke, "R8 restart clears", {done, error, cke}, 0);
                chk(mem_rst == p, "R10 asserted level", mem_rst, p);
            end
        end while (mem_rst == p && k < 1000);
        chk(k == RSTC + 1, "R1 reset hold", k - 1, RSTC);
        j = 0;
        do begin
            @(negedge clk);
            j++;
            start = (poke && j == 5);
        end while (!cke && j < 1000);
        start = 1'b0;
        chk(j == exp_w, poke ? "R7 busy start ignored" : (exp_w == CKEC ? "R2 fixed cke wait" : "R3 scaled cke wait"), j, exp_w);
        chk(init_req == 1'b1, "R4 request with cke", init_req, 1);
        if (do_ack) begin
            repeat (ack_at) @(negedge clk);
            chk(init_req == 1'b1 && !error, "R4 request held", init_req, 1);
            idone = 1'b1;
            @(negedge clk);
            idone = 1'b0;
            chk(!init_req, "R4 request dropped", init_req, 0);
            chk(!tm_en && !error, ack_at == TMOC - 1 ? "R9 last-cycle completion" : "R6 tm disable", {tm_en, error}, 0);
            m = 0;
            do begin @(negedge clk); m++; end while (!tm_en && m < 1000);
            chk(m == CYC, "R6 tm disable length", m, CYC);
            m = 0;
            do begin @(negedge clk); m++; end while (!done && m < 1000);
            chk(m == CYC, "R6 tm enable length", m, CYC);
            chk(!error, "R9 no error after success", error, 0);
        end else begin
            m = 0;
            do begin @(negedge clk); m++; end while (!error && m < 1000);
            chk(m == TMOC, "R5 timeout length", m, TMOC);
            chk(!init_req && !done, "R5 request and done low", {init_req, done}, 0);
        end
    endtask

    task automatic t_reset_state();
        chk(mem_rst == 1'b0, "R10 idle reset low pol", mem_rst, 0);
        chk(!cke && !init_req && !done && !error, "R10 idle outputs", {cke, init_req, done, error}, 0);
        chk(tm_en == 1'b1, "R10 idle tm_en", tm_en, 1);
        pol = 1'b1;
        @(negedge clk);
        chk(mem_rst == 1'b1, "R10 idle reset high pol", mem_rst, 1);
    endtask

    task automatic t_fixed_wait();
        run_seq(1'b0, 17'd10, 1'b0, CKEC, 1'b1, 3, 1'b0);
    endtask

    task automatic t_scaled_hold();
        run_seq(1'b1, 17'd40, 1'b0, 80, 1'b1, 0, 1'b0);
        repeat (10) @(negedge clk);
        chk(done && cke && mem_rst == 1'b0, "R8 done holds", {done, cke, mem_rst}, 3'b110);
    endtask

    task automatic t_scaled3();
        run_seq(1'b0, 17'd40, 1'b1, 120, 1'b1, 5, 1'b0);
    endtask

    task automatic t_timeout();
        run_seq(1'b0, 17'd0, 1'b0, CKEC, 1'b0, 0, 1'b0);
        repeat (10) @(negedge clk);
        chk(error && !done, "R8 error holds", {error, done}, 2'b10);
    endtask

    task automatic t_busy_start();
        run_seq(1'b1, 17'd10, 1'b1, CKEC, 1'b1, 2, 1'b1);
    endtask

    task automatic t_last_cycle_ack();
        run_seq(1'b0, 17'd1, 1'b0, CKEC, 1'b1, TMOC - 1, 1'b0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_fixed_wait();
        t_scaled_hold();
        t_scaled3();
        t_timeout();
        t_busy_start();
        t_last_cycle_ack();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule